// File: doc/BRIEF.md
# Miss-Wait Dependence Tracker

This block keeps, for every physical register, a ready flag, a wait flag and the tag of the outstanding cache miss the register is waiting on. It uses them to sort the instructions held in a small issue queue into three groups. An instruction is truly ready when all its sources are ready. It is pretend ready when at least one source is waiting on a miss and every other source is ready. Otherwise it is not ready. Both ready groups raise an issue request. A pretend-ready instruction is also flagged for diversion to a side buffer, together with the miss tag that the buffer files it under.

When a diverted instruction is granted, its queue slot is freed as though it had executed. Its destination register then inherits the wait flag and the miss tag, so later consumers in the same chain are diverted as well. Miss tags live in a table beside the flags rather than in the register file. The rename stage can read a register's flags and tag through a lookup path.

Top module: `wait_dep_tracker`

## Requirements
- R1: After reset every register is ready (ready=1, wait=0, tag=0) and the queue is empty, so `req_o` and `divert_o` are all zero.
- R2: A load-miss notification sets the named register's wait flag, clears its ready flag and records `miss_idx_i` as its tag, visible the next cycle.
- R3: A valid entry raises `req_o` when each source is ready or waiting. It also raises `divert_o` when at least one source is waiting. An entry with any source that is neither ready nor waiting raises neither.
- R4: For a diverted entry, `div_idx_o` carries the tag of the lowest-numbered waiting source. Source 0 is bits [PREG_W-1:0] of `disp_src_i`.
- R5: A granted entry is freed the next cycle. A granted pretend-ready entry sets its destination's wait flag and copies its tag to it. A granted truly ready entry leaves its destination not ready.
- R6: The `ren_*` outputs show the current ready, wait and tag of each `disp_src_i` source in the same cycle. Dispatch clears the destination's ready and wait flags from the next cycle.
- R7: A miss completion clears the wait flag and sets the ready flag of every register whose wait flag is set and whose tag matches `done_idx_i`. Registers with other tags are unaffected.
- R8: If a pretend-ready entry is granted in the same cycle that its tag completes, its destination becomes ready with wait clear.
- R9: Each register with its bit set in `flush_mask_i` has its wait flag and tag cleared. Each queue entry whose destination is in the mask is invalidated, both by the next cycle.
- R10: A writeback sets the named register's ready flag the next cycle.
- R11: A dispatch is placed in the lowest-numbered free queue entry; bit e of `req_o`, `divert_o` and field e of `div_idx_o` belong to entry e.

Top module ports are listed below with default parameters (32 registers, 8 tags, 8 entries, 2 sources).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_vld_i | input | 1 | Dispatch an instruction into the queue |
| disp_src_i | input | NUM_SRC*PREG_W | Source registers, source s at bits s*PREG_W |
| disp_dst_i | input | PREG_W | Destination register |
| ren_rdy_o | output | NUM_SRC | Ready flag of each dispatch source |
| ren_wait_o | output | NUM_SRC | Wait flag of each dispatch source |
| ren_idx_o | output | NUM_SRC*MISS_W | Miss tag of each dispatch source |
| miss_vld_i | input | 1 | Load miss notification |
| miss_preg_i | input | PREG_W | Destination register of the missing load |
| miss_idx_i | input | MISS_W | Miss tag allocated to that miss |
| wb_vld_i | input | 1 | Normal result writeback |
| wb_preg_i | input | PREG_W | Register written back |
| done_vld_i | input | 1 | Miss completion |
| done_idx_i | input | MISS_W | Tag of the completed miss |
| flush_mask_i | input | NUM_PREGS | Squashed destination registers |
| grant_i | input | IQ_DEPTH | One-hot issue grant from the select arbiter |
| req_o | output | IQ_DEPTH | Per-entry issue request |
| divert_o | output | IQ_DEPTH | Per-entry divert-to-buffer flag |
| div_idx_o | output | IQ_DEPTH*MISS_W | Per-entry miss tag for diversion |

## Verification
Every state change (miss, dispatch, grant, writeback, completion, flush) takes effect at the next rising edge. The per-entry request, divert and tag outputs and the rename lookup are combinational from that state, so each result is due one cycle after its stimulus. The rename lookup also reflects whatever sources are on `disp_src_i` in the same cycle. The bench drives a stimulus just after an edge, clears it just after the following edge, and samples the outputs a moment later. Lookups are taken by placing registers on `disp_src_i` with dispatch low. This lets register state be observed at the ports without disturbing it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SRC_PENDING = 2'd0,
    SRC_READY   = 2'd1,
    SRC_WAITING = 2'd2
  } src_state_e;

  function automatic src_state_e src_state(input logic rdy, input logic wt);
    if (rdy)     return SRC_READY;
    else if (wt) return SRC_WAITING;
    else         return SRC_PENDING;
  endfunction
endpackage

// File: rtl/wdt_reg_table.sv
module wdt_reg_table #(
  parameter int NUM_PREGS = 32,
  parameter int NUM_MISS  = 8,
  parameter int NUM_RD    = 4,
  localparam int PREG_W   = $clog2(NUM_PREGS),
  localparam int MISS_W   = $clog2(NUM_MISS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [PREG_W-1:0]           rd_addr_i [NUM_RD],
  output logic                        rd_rdy_o  [NUM_RD],
  output logic                        rd_wait_o [NUM_RD],
  output logic [MISS_W-1:0]           rd_idx_o  [NUM_RD],
  input  logic                        alloc_vld_i,
  input  logic [PREG_W-1:0]           alloc_preg_i,
  input  logic                        miss_vld_i,
  input  logic [PREG_W-1:0]           miss_preg_i,
  input  logic [MISS_W-1:0]           miss_idx_i,
  input  logic                        div_vld_i,
  input  logic [PREG_W-1:0]           div_preg_i,
  input  logic [MISS_W-1:0]           div_idx_i,
  input  logic                        wb_vld_i,
  input  logic [PREG_W-1:0]           wb_preg_i,
  input  logic                        done_vld_i,
  input  logic [MISS_W-1:0]           done_idx_i,
  input  logic [NUM_PREGS-1:0]        flush_mask_i,
  output logic [NUM_PREGS-1:0]        wait_vec_o,
  output logic [NUM_PREGS*MISS_W-1:0] idx_vec_o
);
  logic [NUM_PREGS-1:0] rdy_q, rdy_d, wait_q, wait_d;
  logic [MISS_W-1:0]    idx_q [NUM_PREGS];
  logic [MISS_W-1:0]    idx_d [NUM_PREGS];

  // divert whose miss completes this very cycle must not be left waiting
  logic div_done_race;
  assign div_done_race = done_vld_i && (done_idx_i == div_idx_i);

  always_comb begin
    for (int r = 0; r < NUM_PREGS; r++) begin
      rdy_d[r]  = rdy_q[r];
      wait_d[r] = wait_q[r];
      idx_d[r]  = idx_q[r];
      if (done_vld_i && wait_q[r] && idx_q[r] == done_idx_i) begin
        wait_d[r] = 1'b0;
        rdy_d[r]  = 1'b1;
      end
      if (alloc_vld_i && alloc_preg_i == PREG_W'(r)) begin
        rdy_d[r]  = 1'b0;
        wait_d[r] = 1'b0;
        idx_d[r]  = '0;
      end
      if (miss_vld_i && miss_preg_i == PREG_W'(r)) begin
        rdy_d[r]  = 1'b0;
        wait_d[r] = 1'b1;
        idx_d[r]  = miss_idx_i;
      end
      if (div_vld_i && div_preg_i == PREG_W'(r)) begin
        rdy_d[r]  = div_done_race;
        wait_d[r] = !div_done_race;
        idx_d[r]  = div_idx_i;
      end
      if (wb_vld_i && wb_preg_i == PREG_W'(r)) rdy_d[r] = 1'b1;
      if (flush_mask_i[r]) begin
        wait_d[r] = 1'b0;
        idx_d[r]  = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= '1;
      wait_q <= '0;
      for (int r = 0; r < NUM_PREGS; r++) idx_q[r] <= '0;
    end else begin
      rdy_q  <= rdy_d;
      wait_q <= wait_d;
      for (int r = 0; r < NUM_PREGS; r++) idx_q[r] <= idx_d[r];
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_rdy_o[p]  = rdy_q[rd_addr_i[p]];
    assign rd_wait_o[p] = wait_q[rd_addr_i[p]];
    assign rd_idx_o[p]  = idx_q[rd_addr_i[p]];
  end

  assign wait_vec_o = wait_q;
  for (genvar r = 0; r < NUM_PREGS; r++) begin : g_vec
    assign idx_vec_o[r*MISS_W +: MISS_W] = idx_q[r];
  end
endmodule

// File: rtl/wdt_entry_classify.sv
module wdt_entry_classify #(
  parameter int NUM_SRC = 2,
  parameter int MISS_W  = 3
) (
  input  logic              valid_i,
  input  logic              rdy_i  [NUM_SRC],
  input  logic              wait_i [NUM_SRC],
  input  logic [MISS_W-1:0] idx_i  [NUM_SRC],
  output logic              req_o,
  output logic              divert_o,
  output logic [MISS_W-1:0] idx_o
);
  import wdt_pkg::*;
  logic all_ok, any_wait;
  src_state_e st;

  always_comb begin
    all_ok   = 1'b1;
    any_wait = 1'b0;
    idx_o    = '0;
    st       = SRC_PENDING;
    // walk downward so the lowest-numbered waiting source wins
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      st = src_state(rdy_i[s], wait_i[s]);
      if (st == SRC_PENDING) all_ok = 1'b0;
      if (st == SRC_WAITING) begin
        any_wait = 1'b1;
        idx_o    = idx_i[s];
      end
    end
    req_o    = valid_i && all_ok;
    divert_o = valid_i && all_ok && any_wait;
  end
endmodule

// File: rtl/wdt_issue_queue.sv
module wdt_issue_queue #(
  parameter int DEPTH     = 8,
  parameter int NUM_SRC   = 2,
  parameter int NUM_PREGS = 32,
  localparam int PREG_W   = $clog2(NUM_PREGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 disp_vld_i,
  input  logic [PREG_W-1:0]    disp_src_i [NUM_SRC],
  input  logic [PREG_W-1:0]    disp_dst_i,
  input  logic [DEPTH-1:0]     grant_i,
  input  logic [NUM_PREGS-1:0] flush_mask_i,
  output logic [DEPTH-1:0]     valid_o,
  output logic [PREG_W-1:0]    src_o [DEPTH][NUM_SRC],
  output logic [PREG_W-1:0]    dst_o [DEPTH]
);
  logic [DEPTH-1:0]  valid_q, alloc_oh;
  logic [PREG_W-1:0] src_q [DEPTH][NUM_SRC];
  logic [PREG_W-1:0] dst_q [DEPTH];

  always_comb begin
    alloc_oh = '0;
    for (int e = 0; e < DEPTH; e++)
      if (!valid_q[e] && alloc_oh == '0) alloc_oh[e] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (valid_q[e] && (grant_i[e] || flush_mask_i[dst_q[e]])) valid_q[e] <= 1'b0;
        else if (disp_vld_i && alloc_oh[e])                      valid_q[e] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (disp_vld_i && alloc_oh[e]) begin
        dst_q[e] <= disp_dst_i;
        for (int s = 0; s < NUM_SRC; s++) src_q[e][s] <= disp_src_i[s];
      end
    end
  end

  assign valid_o = valid_q;
  assign src_o   = src_q;
  assign dst_o   = dst_q;
endmodule

// File: rtl/wait_dep_tracker.sv
module wait_dep_tracker #(
  parameter int NUM_PREGS = 32,
  parameter int NUM_MISS  = 8,
  parameter int IQ_DEPTH  = 8,
  parameter int NUM_SRC   = 2,
  localparam int PREG_W   = $clog2(NUM_PREGS),
  localparam int MISS_W   = $clog2(NUM_MISS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       disp_vld_i,
  input  logic [NUM_SRC*PREG_W-1:0]  disp_src_i,
  input  logic [PREG_W-1:0]          disp_dst_i,
  output logic [NUM_SRC-1:0]         ren_rdy_o,
  output logic [NUM_SRC-1:0]         ren_wait_o,
  output logic [NUM_SRC*MISS_W-1:0]  ren_idx_o,
  input  logic                       miss_vld_i,
  input  logic [PREG_W-1:0]          miss_preg_i,
  input  logic [MISS_W-1:0]          miss_idx_i,
  input  logic                       wb_vld_i,
  input  logic [PREG_W-1:0]          wb_preg_i,
  input  logic                       done_vld_i,
  input  logic [MISS_W-1:0]          done_idx_i,
  input  logic [NUM_PREGS-1:0]       flush_mask_i,
  input  logic [IQ_DEPTH-1:0]        grant_i,
  output logic [IQ_DEPTH-1:0]        req_o,
  output logic [IQ_DEPTH-1:0]        divert_o,
  output logic [IQ_DEPTH*MISS_W-1:0] div_idx_o
);
  localparam int IQ_RD  = IQ_DEPTH * NUM_SRC;
  localparam int NUM_RD = IQ_RD + NUM_SRC;

  logic [PREG_W-1:0] disp_src [NUM_SRC];
  logic [PREG_W-1:0] rd_addr  [NUM_RD];
  logic              rd_rdy   [NUM_RD];
  logic              rd_wait  [NUM_RD];
  logic [MISS_W-1:0] rd_idx   [NUM_RD];

  logic [IQ_DEPTH-1:0] iq_valid;
  logic [PREG_W-1:0]   iq_src [IQ_DEPTH][NUM_SRC];
  logic [PREG_W-1:0]   iq_dst [IQ_DEPTH];
  logic [MISS_W-1:0]   ent_idx [IQ_DEPTH];

  logic                      div_vld;
  logic [PREG_W-1:0]         div_preg;
  logic [MISS_W-1:0]         div_idx;
  logic [NUM_PREGS-1:0]      reg_wait;
  logic [NUM_PREGS*MISS_W-1:0] reg_idx;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign disp_src[s]                 = disp_src_i[s*PREG_W +: PREG_W];
    assign rd_addr[IQ_RD + s]          = disp_src[s];
    assign ren_rdy_o[s]                = rd_rdy[IQ_RD + s];
    assign ren_wait_o[s]               = rd_wait[IQ_RD + s];
    assign ren_idx_o[s*MISS_W +: MISS_W] = rd_idx[IQ_RD + s];
  end

  wdt_issue_queue #(
    .DEPTH(IQ_DEPTH), .NUM_SRC(NUM_SRC), .NUM_PREGS(NUM_PREGS)
  ) u_iq (
    .clk_i, .rst_ni,
    .disp_vld_i, .disp_src_i(disp_src), .disp_dst_i,
    .grant_i, .flush_mask_i,
    .valid_o(iq_valid), .src_o(iq_src), .dst_o(iq_dst)
  );

  for (genvar e = 0; e < IQ_DEPTH; e++) begin : g_ent
    logic              e_rdy  [NUM_SRC];
    logic              e_wait [NUM_SRC];
    logic [MISS_W-1:0] e_idx  [NUM_SRC];
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_port
      assign rd_addr[e*NUM_SRC + s] = iq_src[e][s];
      assign e_rdy[s]  = rd_rdy[e*NUM_SRC + s];
      assign e_wait[s] = rd_wait[e*NUM_SRC + s];
      assign e_idx[s]  = rd_idx[e*NUM_SRC + s];
    end
    wdt_entry_classify #(.NUM_SRC(NUM_SRC), .MISS_W(MISS_W)) u_cls (
      .valid_i(iq_valid[e]), .rdy_i(e_rdy), .wait_i(e_wait), .idx_i(e_idx),
      .req_o(req_o[e]), .divert_o(divert_o[e]), .idx_o(ent_idx[e])
    );
    assign div_idx_o[e*MISS_W +: MISS_W] = ent_idx[e];
  end

  // grant is one-hot: at most one destination update per cycle
  always_comb begin
    div_vld  = 1'b0;
    div_preg = '0;
    div_idx  = '0;
    for (int e = 0; e < IQ_DEPTH; e++) begin
      if (grant_i[e] && divert_o[e]) begin
        div_vld  = 1'b1;
        div_preg = iq_dst[e];
        div_idx  = ent_idx[e];
      end
    end
  end

  wdt_reg_table #(
    .NUM_PREGS(NUM_PREGS), .NUM_MISS(NUM_MISS), .NUM_RD(NUM_RD)
  ) u_tbl (
    .clk_i, .rst_ni,
    .rd_addr_i(rd_addr), .rd_rdy_o(rd_rdy), .rd_wait_o(rd_wait), .rd_idx_o(rd_idx),
    .alloc_vld_i(disp_vld_i), .alloc_preg_i(disp_dst_i),
    .miss_vld_i, .miss_preg_i, .miss_idx_i,
    .div_vld_i(div_vld), .div_preg_i(div_preg), .div_idx_i(div_idx),
    .wb_vld_i, .wb_preg_i,
    .done_vld_i, .done_idx_i,
    .flush_mask_i,
    .wait_vec_o(reg_wait), .idx_vec_o(reg_idx)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int NUM_PREGS = 32,
  parameter int MISS_W    = 3,
  parameter int PREG_W    = 5,
  parameter int IQ_DEPTH  = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        disp_vld_i,
  input logic                        miss_vld_i,
  input logic [PREG_W-1:0]           miss_preg_i,
  input logic                        done_vld_i,
  input logic [MISS_W-1:0]           done_idx_i,
  input logic [NUM_PREGS-1:0]        flush_mask_i,
  input logic [IQ_DEPTH-1:0]         grant_i,
  input logic [IQ_DEPTH-1:0]         req_o,
  input logic [IQ_DEPTH-1:0]         divert_o,
  input logic [NUM_PREGS-1:0]        reg_wait,
  input logic [NUM_PREGS*MISS_W-1:0] reg_idx
);
  a_r3_divert_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divert_o & ~req_o) == '0);

  a_r5_grant_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i != '0) |=> ((req_o & $past(grant_i)) == '0));

  a_r2_miss_sets_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_vld_i && !disp_vld_i && flush_mask_i == '0) |=> reg_wait[$past(miss_preg_i)]);

  for (genvar r = 0; r < NUM_PREGS; r++) begin : g_reg
    a_r7_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_vld_i && reg_wait[r] && reg_idx[r*MISS_W +: MISS_W] == done_idx_i &&
       !(miss_vld_i && miss_preg_i == PREG_W'(r)) && grant_i == '0)
      |=> !reg_wait[r]);

    a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_mask_i[r] |=> !reg_wait[r]);
  end
endmodule

bind wait_dep_tracker wdt_checker #(
  .NUM_PREGS(NUM_PREGS), .MISS_W(MISS_W), .PREG_W(PREG_W), .IQ_DEPTH(IQ_DEPTH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .disp_vld_i(disp_vld_i),
  .miss_vld_i(miss_vld_i), .miss_preg_i(miss_preg_i),
  .done_vld_i(done_vld_i), .done_idx_i(done_idx_i),
  .flush_mask_i(flush_mask_i), .grant_i(grant_i),
  .req_o(req_o), .divert_o(divert_o),
  .reg_wait(reg_wait), .reg_idx(reg_idx)
);

// File: tb/wait_dep_tracker_tb.sv
module wait_dep_tracker_tb_top;
  localparam int NP = 32, NM = 8, IQ = 8, NS = 2, PW = 5, MW = 3;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            disp_vld_i = 1'b0;
  logic [NS*PW-1:0] disp_src_i = '0;
  logic [PW-1:0]   disp_dst_i = '0;
  logic [NS-1:0]   ren_rdy_o, ren_wait_o;
  logic [NS*MW-1:0] ren_idx_o;
  logic            miss_vld_i = 1'b0;
  logic [PW-1:0]   miss_preg_i = '0;
  logic [MW-1:0]   miss_idx_i = '0;
  logic            wb_vld_i = 1'b0;
  logic [PW-1:0]   wb_preg_i = '0;
  logic            done_vld_i = 1'b0;
  logic [MW-1:0]   done_idx_i = '0;
  logic [NP-1:0]   flush_mask_i = '0;
  logic [IQ-1:0]   grant_i = '0;
  logic [IQ-1:0]   req_o, divert_o;
  logic [IQ*MW-1:0] div_idx_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  wait_dep_tracker #(.NUM_PREGS(NP), .NUM_MISS(NM), .IQ_DEPTH(IQ), .NUM_SRC(NS)) dut_i (.*);

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
    disp_vld_i = 1'b0; miss_vld_i = 1'b0; wb_vld_i = 1'b0;
    done_vld_i = 1'b0; flush_mask_i = '0; grant_i = '0;
    #1;
  endtask

  task automatic look(input int a, input int b);
    disp_src_i = {PW'(b), PW'(a)};
    #1;
  endtask

  task automatic disp(input int a, input int b, input int d);
    disp_vld_i = 1'b1; disp_src_i = {PW'(b), PW'(a)}; disp_dst_i = PW'(d);
    step();
  endtask

  task automatic miss(input int p, input int t);
    miss_vld_i = 1'b1; miss_preg_i = PW'(p); miss_idx_i = MW'(t);
    step();
  endtask

  function automatic int eidx(input int e);
    return int'(div_idx_o[e*MW +: MW]);
  endfunction

  task automatic t_reset();
    chk("R1 req after reset", int'(req_o), 0);
    chk("R1 divert after reset", int'(divert_o), 0);
    look(3, 4);
    chk("R1 ready after reset", int'(ren_rdy_o), 3);
    chk("R1 wait after reset", int'(ren_wait_o), 0);
    chk("R6 tag lookup after reset", int'(ren_idx_o), 0);
  endtask

  task automatic t_truly();
    disp(1, 2, 10);
    chk("R11 first entry used", int'(req_o), 1);
    chk("R3 truly ready not diverted", int'(divert_o), 0);
    look(10, 1);
    chk("R6 dispatch clears dest ready", int'(ren_rdy_o), 2);
    grant_i = 8'h01; step();
    chk("R5 granted entry freed", int'(req_o), 0);
    look(10, 10);
    chk("R5 truly grant leaves dest not ready", int'(ren_rdy_o), 0);
    wb_vld_i = 1'b1; wb_preg_i = 5'd10; step();
    look(10, 10);
    chk("R10 writeback sets ready", int'(ren_rdy_o), 3);
  endtask

  task automatic t_pretend();
    miss(5, 3);
    look(5, 1);
    chk("R2 miss clears ready", int'(ren_rdy_o), 2);
    chk("R2 miss sets wait", int'(ren_wait_o), 1);
    chk("R2 miss tag recorded", int'(ren_idx_o[MW-1:0]), 3);
    disp(5, 1, 11);
    disp(11, 2, 14);
    chk("R3 pending source blocks request", int'(req_o), 1);
    chk("R3 pretend ready diverted", int'(divert_o), 1);
    chk("R4 divert tag entry0", eidx(0), 3);
    grant_i = 8'h01; step();
    look(11, 14);
    chk("R5 divert sets dest wait", int'(ren_wait_o), 1);
    chk("R5 divert copies tag", int'(ren_idx_o[MW-1:0]), 3);
    chk("R5 diverted dest not ready", int'(ren_rdy_o), 0);
    chk("R5 chain consumer requests", int'(req_o), 2);
    chk("R5 chain consumer diverted", int'(divert_o), 2);
    chk("R5 chain consumer tag", eidx(1), 3);
  endtask

  task automatic t_order();
    miss(7, 5);
    disp(7, 5, 15);
    disp(5, 7, 16);
    chk("R11 lowest free entries", int'(req_o), 7);
    chk("R4 all three diverted", int'(divert_o), 7);
    chk("R4 source0 tag wins entry0", eidx(0), 5);
    chk("R4 source0 tag wins entry2", eidx(2), 3);
  endtask

  task automatic t_done();
    done_vld_i = 1'b1; done_idx_i = 3'd3; step();
    look(5, 11);
    chk("R7 matching regs ready", int'(ren_rdy_o), 3);
    chk("R7 matching regs wait clear", int'(ren_wait_o), 0);
    look(7, 7);
    chk("R7 other tag still waiting", int'(ren_wait_o), 3);
    chk("R7 other tag kept", int'(ren_idx_o[MW-1:0]), 5);
    chk("R7 requests after completion", int'(req_o), 7);
    chk("R7 consumer now truly ready", int'(divert_o), 5);
    chk("R4 remaining waiting source tag", eidx(2), 5);
  endtask

  task automatic t_race();
    grant_i = 8'h04; done_vld_i = 1'b1; done_idx_i = 3'd5; step();
    look(16, 7);
    chk("R8 race dest ready", int'(ren_rdy_o), 3);
    chk("R8 race dest wait clear", int'(ren_wait_o), 0);
    chk("R8 remaining requests", int'(req_o), 3);
    chk("R8 no diverts left", int'(divert_o), 0);
  endtask

  task automatic t_flush();
    miss(20, 1);
    disp(20, 1, 21);
    chk("R9 pre-flush divert", int'(divert_o), 4);
    chk("R9 pre-flush tag", eidx(2), 1);
    flush_mask_i = (32'd1 << 20) | (32'd1 << 21); step();
    chk("R9 flushed entry invalid", int'(req_o), 3);
    look(20, 20);
    chk("R9 flushed wait clear", int'(ren_wait_o), 0);
    chk("R9 flushed tag clear", int'(ren_idx_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step();
    t_reset();
    t_truly();
    t_pretend();
    t_order();
    t_done();
    t_race();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule